// File: doc/BRIEF.md
# Gated I2C Bus Repeater

This block connects a host I2C bus to a secondary bus on the tuner side. The secondary bus sees traffic only when software asks for it, so the tuner side stays quiet for the rest of the time. Software sets an arm bit. The next message on the host bus is then repeated onto the secondary clock and data lines, from its start condition to its stop condition. The message may have any address and any length, and data passes in both directions. The arm bit clears itself when that stop condition is seen.

Each line (clock and data) decides its own direction. The side that pulls the line low first owns it until it lets go. While it owns the line, the repeater pulls the other side low for it. When the owner releases the line, a programmable blanking window starts. During this window a low level on the other side is ignored. This gives the line that is still rising time to rise, so the two buses do not latch each other low. When no message is being repeated, the two secondary pull-low enables act as general-purpose open-drain outputs. The level of the secondary data line is available as a registered status bit.

All line inputs are bus levels that are already synchronous to `clk_i`. The outputs are pull-low enables for external open-drain pads. A 1 on an enable pulls the line low.

Top module: `i2c_gated_repeater`

## Requirements
- R1: After reset, `arm_o` and `active_o` are 0. Both host enables are 0, the secondary enables equal the inverted general-purpose inputs, and `sec_sda_stat_o` is 1.
- R2: A one-cycle pulse on `arm_set_i` sets `arm_o` at the next rising clock edge. `arm_o` stays 1 for as long as `active_o` is 1. `active_o` rises only at a host start condition (SDA falls while SCL stays high) seen while `arm_o` is 1.
- R3: A host stop condition (SDA rises while SCL stays high) seen while `active_o` is 1 clears both `active_o` and `arm_o` at that clock edge. Later messages are not repeated until the block is armed again.
- R4: While `active_o` is 1, a low level on a host line with that line unowned pulls the secondary line low from the next clock edge. The secondary line is released on the edge after the host releases. A repeated start does not end repetition.
- R5: While `active_o` is 1, a low level on an unowned secondary line pulls the host line low from the next clock edge. The host enables are never 1 while `active_o` is 0.
- R6: The side that pulled a line low first owns it. A low level on the other side is ignored while the owner holds the line low. If both sides go low in the same cycle, the host side wins.
- R7: `dly_sel_i` values 0, 1, 2 and 3 select a blanking window of 0, 4, 8 and 16 clocks (unit `DLY_UNIT`=4). A release by the owner that is presented before clock edge e0 lets the opposite side take the line no earlier than edge e0+D+1, where D is the window length.
- R8: While `active_o` is 0, `sec_scl_oe_o` equals the inverse of `gpo_scl_i` and `sec_sda_oe_o` equals the inverse of `gpo_sda_i`, without delay. A general-purpose value of 0 pulls the line low.
- R9: An arm request that arrives after an unrepeated message has started does not repeat the rest of that message. `arm_o` is still 1 after that message's stop condition, and repetition begins at the next start condition.
- R10: `sec_sda_stat_o` is the level of `sec_sda_i` registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_set_i | input | 1 | One-cycle write pulse that sets the arm bit |
| dly_sel_i | input | 2 | Blanking window select |
| gpo_scl_i | input | 1 | General-purpose value for the secondary clock pin when not repeating |
| gpo_sda_i | input | 1 | General-purpose value for the secondary data pin when not repeating |
| host_scl_i | input | 1 | Host bus clock level |
| host_sda_i | input | 1 | Host bus data level |
| sec_scl_i | input | 1 | Secondary bus clock level |
| sec_sda_i | input | 1 | Secondary bus data level |
| host_scl_oe_o | output | 1 | Pull host clock low |
| host_sda_oe_o | output | 1 | Pull host data low |
| sec_scl_oe_o | output | 1 | Pull secondary clock low |
| sec_sda_oe_o | output | 1 | Pull secondary data low |
| arm_o | output | 1 | Arm bit readback |
| active_o | output | 1 | A message is being repeated |
| sec_sda_stat_o | output | 1 | Registered secondary data level |

## Verification
The ownership assertions assume three things about the inputs. Line levels are synchronous to the clock. Data on the host bus changes only while SCL is low, except at start and stop conditions. The repeater's own enable is seen on the bus level in the following cycle. The bench models each bus as a wired-AND of the agent's pull-low and the repeater's enable. It moves SDA only a few clocks into each SCL low phase, with half periods of 24 clocks. That is longer than the 16-clock window plus the two-edge hand-over, so every forwarded bit settles before it is sampled.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [2:0] {
    LN_IDLE = 3'd0,
    LN_HOST = 3'd1,
    LN_SEC  = 3'd2,
    LN_HBLK = 3'd3,
    LN_SBLK = 3'd4
  } ln_state_e;

  localparam int unsigned LN_SCL  = 0;
  localparam int unsigned LN_SDA  = 1;
  localparam int unsigned N_LINES = 2;

  function automatic int unsigned dly_cycles(input logic [1:0] sel, input int unsigned unit);
    case (sel)
      2'd0:    return 0;
      2'd1:    return unit;
      2'd2:    return 2 * unit;
      default: return 4 * unit;
    endcase
  endfunction

endpackage

// File: rtl/rpt_cond.sv
module rpt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // edges on SDA with SCL held high across both samples
  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;

endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_set_i,
  input  logic start_i,
  input  logic stop_i,
  output logic arm_o,
  output logic active_o
);

  logic arm_q, active_q;
  logic end_msg;

  assign end_msg = active_q & stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (end_msg)        arm_q <= 1'b0;
      else if (arm_set_i) arm_q <= 1'b1;

      if (end_msg)                 active_q <= 1'b0;
      else if (arm_q && start_i)   active_q <= 1'b1;
    end
  end

  assign arm_o    = arm_q;
  assign active_o = active_q;

  AST_ARM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> arm_q);  // R2
  AST_START_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(arm_q) && $past(start_i));  // R2
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stop_i) |=> (!arm_q && !active_q));  // R3

endmodule

// File: rtl/rpt_line.sv
module rpt_line
  import rpt_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic             host_lvl_i,
  input  logic             sec_lvl_i,
  input  logic             gpo_i,
  output logic             host_oe_o,
  output logic             sec_oe_o
);

  ln_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dly_zero, cnt_last;

  assign dly_zero = (dly_i == '0);
  assign cnt_last = (cnt_q <= CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!active_i) begin
      st_d  = LN_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        LN_IDLE: begin
          if (!host_lvl_i)     st_d = LN_HOST;  // host wins a tie
          else if (!sec_lvl_i) st_d = LN_SEC;
        end
        LN_HOST: begin
          if (host_lvl_i) begin
            if (dly_zero) st_d = LN_IDLE;
            else begin
              st_d  = LN_HBLK;
              cnt_d = dly_i;
            end
          end
        end
        LN_SEC: begin
          if (sec_lvl_i) begin
            if (dly_zero) st_d = LN_IDLE;
            else begin
              st_d  = LN_SBLK;
              cnt_d = dly_i;
            end
          end
        end
        LN_HBLK: begin
          // secondary still rising: only a fresh host low is honoured
          if (!host_lvl_i)   st_d = LN_HOST;
          else if (cnt_last) st_d = LN_IDLE;
          else               cnt_d = cnt_q - CNT_W'(1);
        end
        LN_SBLK: begin
          if (!sec_lvl_i)    st_d = LN_SEC;
          else if (cnt_last) st_d = LN_IDLE;
          else               cnt_d = cnt_q - CNT_W'(1);
        end
        default: st_d = LN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign host_oe_o = active_i && (st_q == LN_SEC);
  assign sec_oe_o  = active_i ? (st_q == LN_HOST) : !gpo_i;

  AST_HOST_OWNER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && st_q == LN_HOST && !host_lvl_i) |=> sec_oe_o);  // R6
  AST_SEC_OWNER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && st_q == LN_SEC && !sec_lvl_i) |=> host_oe_o);  // R6
  AST_BLANK_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && st_q == LN_HBLK && host_lvl_i && !cnt_last) |=> !host_oe_o);  // R7

endmodule

// File: rtl/i2c_gated_repeater.sv
module i2c_gated_repeater
  import rpt_pkg::*;
#(
  parameter int unsigned DLY_UNIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_set_i,
  input  logic [1:0] dly_sel_i,
  input  logic       gpo_scl_i,
  input  logic       gpo_sda_i,
  input  logic       host_scl_i,
  input  logic       host_sda_i,
  input  logic       sec_scl_i,
  input  logic       sec_sda_i,
  output logic       host_scl_oe_o,
  output logic       host_sda_oe_o,
  output logic       sec_scl_oe_o,
  output logic       sec_sda_oe_o,
  output logic       arm_o,
  output logic       active_o,
  output logic       sec_sda_stat_o
);

  localparam int unsigned MAX_DLY = 4 * DLY_UNIT;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1) < 1 ? 1 : $clog2(MAX_DLY + 1);

  logic             start, stop, active;
  logic [CNT_W-1:0] dly_cyc;
  logic [N_LINES-1:0] host_lvl, sec_lvl, gpo, host_oe, sec_oe;
  logic             stat_q;

  assign dly_cyc  = CNT_W'(dly_cycles(dly_sel_i, DLY_UNIT));
  assign host_lvl = {host_sda_i, host_scl_i};
  assign sec_lvl  = {sec_sda_i, sec_scl_i};
  assign gpo      = {gpo_sda_i, gpo_scl_i};

  rpt_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (host_scl_i),
    .sda_i  (host_sda_i),
    .start_o(start),
    .stop_o (stop)
  );

  rpt_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_set_i(arm_set_i),
    .start_i  (start),
    .stop_i   (stop),
    .arm_o    (arm_o),
    .active_o (active)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    rpt_line #(.CNT_W(CNT_W)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (active),
      .dly_i     (dly_cyc),
      .host_lvl_i(host_lvl[g]),
      .sec_lvl_i (sec_lvl[g]),
      .gpo_i     (gpo[g]),
      .host_oe_o (host_oe[g]),
      .sec_oe_o  (sec_oe[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b1;
    else         stat_q <= sec_sda_i;
  end

  assign host_scl_oe_o  = host_oe[LN_SCL];
  assign host_sda_oe_o  = host_oe[LN_SDA];
  assign sec_scl_oe_o   = sec_oe[LN_SCL];
  assign sec_sda_oe_o   = sec_oe[LN_SDA];
  assign active_o       = active;
  assign sec_sda_stat_o = stat_q;

  AST_HOST_FREE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (!host_scl_oe_o && !host_sda_oe_o));  // R5
  AST_ARM_BEFORE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> arm_o);  // R9

endmodule

// File: tb/sim_i2c_gated_repeater.sv
`timescale 1ns/1ps
module sim_i2c_gated_repeater;

  localparam int HP = 24;

  logic clk = 1'b0;
  logic rst_ni;
  logic arm_set_i;
  logic [1:0] dly_sel_i;
  logic gpo_scl_i, gpo_sda_i;
  logic m_scl_low, m_sda_low, s_scl_low, s_sda_low;
  logic h_scl, h_sda, s_scl, s_sda;
  logic host_scl_oe_o, host_sda_oe_o, sec_scl_oe_o, sec_sda_oe_o;
  logic arm_o, active_o, sec_sda_stat_o;

  int total = 0;
  int bad = 0;
  bit arm_m = 0;

  always #10 clk = ~clk;

  assign h_scl = ~(m_scl_low | host_scl_oe_o);
  assign h_sda = ~(m_sda_low | host_sda_oe_o);
  assign s_scl = ~(s_scl_low | sec_scl_oe_o);
  assign s_sda = ~(s_sda_low | sec_sda_oe_o);

  i2c_gated_repeater u0 (
    .clk_i(clk), .rst_ni(rst_ni), .arm_set_i(arm_set_i), .dly_sel_i(dly_sel_i),
    .gpo_scl_i(gpo_scl_i), .gpo_sda_i(gpo_sda_i),
    .host_scl_i(h_scl), .host_sda_i(h_sda), .sec_scl_i(s_scl), .sec_sda_i(s_sda),
    .host_scl_oe_o(host_scl_oe_o), .host_sda_oe_o(host_sda_oe_o),
    .sec_scl_oe_o(sec_scl_oe_o), .sec_sda_oe_o(sec_sda_oe_o),
    .arm_o(arm_o), .active_o(active_o), .sec_sda_stat_o(sec_sda_stat_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int dly_of(input logic [1:0] sel);
    return (sel == 2'd3) ? 16 : 4 * int'(sel);
  endfunction

  task automatic pulse_arm();
    arm_set_i = 1'b1;
    tick(1);
    arm_set_i = 1'b0;
    arm_m = 1'b1;
    chk("R2 arm set", {7'd0, arm_o}, 8'd1);
  endtask

  task automatic send_start(input bit rep);
    m_sda_low = 1'b1;
    tick(HP);
    chk("R2 active at start", {7'd0, active_o}, {7'd0, rep});
    if (rep) chk("R4 start forwarded", {6'd0, s_scl, s_sda}, 8'b10);
    else     chk("R3 sec quiet", {6'd0, s_scl, s_sda}, 8'b11);
  endtask

  task automatic bit_x(input bit from_host, input bit b, input bit rep);
    m_scl_low = 1'b1;
    tick(2);
    s_sda_low = !from_host && !b;
    tick(2);
    m_sda_low = from_host && !b;
    tick(HP - 4);
    if (rep) chk("R4 scl low forwarded", {7'd0, s_scl}, 8'd0);
    m_scl_low = 1'b0;
    tick(HP);
    if (rep) begin
      if (from_host) chk("R4 host data to sec", {6'd0, s_scl, s_sda}, {6'd0, 1'b1, b});
      else           chk("R5 sec data to host", {7'd0, h_sda}, {7'd0, b});
    end else begin
      chk("R3 sec idle unarmed", {6'd0, s_scl, s_sda}, 8'b11);
    end
  endtask

  task automatic send_stop(input bit rep);
    m_scl_low = 1'b1;
    tick(2);
    s_sda_low = 1'b0;
    tick(2);
    m_sda_low = 1'b1;
    tick(HP - 4);
    m_scl_low = 1'b0;
    tick(HP);
    m_sda_low = 1'b0;
    tick(HP);
    if (rep) arm_m = 1'b0;
    chk("R3 stop clears", {6'd0, arm_o, active_o}, {6'd0, arm_m, 1'b0});
  endtask

  task automatic run_msg(input bit arm_mid);
    bit rep;
    int nbytes;
    rep = arm_m;
    nbytes = 1 + int'($urandom_range(1));
    send_start(rep);
    for (int i = 0; i < 8; i++) bit_x(1'b1, 1'($urandom_range(1)), rep);
    bit_x(!rep, !rep, rep);
    if (arm_mid) begin
      pulse_arm();  // R9: mid-message request
    end
    for (int k = 0; k < nbytes; k++) begin
      bit rd;
      rd = rep && ($urandom_range(1) == 1);
      for (int i = 0; i < 8; i++) bit_x(!rd, 1'($urandom_range(1)), rep);
      if (rd)       bit_x(1'b1, 1'b0, rep);
      else if (rep) bit_x(1'b0, 1'b0, rep);
      else          bit_x(1'b1, 1'b1, rep);
    end
    send_stop(rep);
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0;
    arm_set_i = 1'b0; dly_sel_i = 2'd0;
    gpo_scl_i = 1'b1; gpo_sda_i = 1'b1;
    m_scl_low = 1'b0; m_sda_low = 1'b0; s_scl_low = 1'b0; s_sda_low = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    chk("R1 reset ctrl", {6'd0, arm_o, active_o}, 8'd0);
    chk("R1 reset enables", {4'd0, host_scl_oe_o, host_sda_oe_o, sec_scl_oe_o, sec_sda_oe_o}, 8'd0);
    chk("R1 reset status", {7'd0, sec_sda_stat_o}, 8'd1);

    for (int i = 0; i < 8; i++) begin
      logic a, b;
      a = 1'($urandom_range(1)); b = 1'($urandom_range(1));
      gpo_scl_i = a; gpo_sda_i = b;
      tick(1);
      chk("R8 gpo", {6'd0, sec_scl_oe_o, sec_sda_oe_o}, {6'd0, !a, !b});
    end
    gpo_scl_i = 1'b0; gpo_sda_i = 1'b0;
    tick(1);
    chk("R5 host free while idle", {6'd0, host_scl_oe_o, host_sda_oe_o}, 8'd0);
    chk("R10 status follows gpo low", {7'd0, sec_sda_stat_o}, 8'd0);
    gpo_scl_i = 1'b1; gpo_sda_i = 1'b1;
    tick(1);
    chk("R10 status high", {7'd0, sec_sda_stat_o}, 8'd1);
    s_sda_low = 1'b1;
    tick(1);
    chk("R10 status slave low", {7'd0, sec_sda_stat_o}, 8'd0);
    s_sda_low = 1'b0;
    tick(2);

    run_msg(1'b0);
    run_msg(1'b1);
    chk("R9 arm kept after unrepeated message", {7'd0, arm_o}, 8'd1);
    run_msg(1'b0);

    // R4 repeated start keeps repetition
    pulse_arm();
    send_start(1'b1);
    for (int i = 0; i < 8; i++) bit_x(1'b1, 1'($urandom_range(1)), 1'b1);
    bit_x(1'b0, 1'b0, 1'b1);
    m_scl_low = 1'b1; tick(2); s_sda_low = 1'b0; tick(2); m_sda_low = 1'b0;
    tick(HP - 4); m_scl_low = 1'b0; tick(HP); m_sda_low = 1'b1; tick(HP);
    chk("R4 repeated start", {6'd0, arm_o, active_o}, 8'b11);
    chk("R4 repeated start on sec", {6'd0, s_scl, s_sda}, 8'b10);
    for (int i = 0; i < 8; i++) bit_x(1'b1, 1'($urandom_range(1)), 1'b1);
    bit_x(1'b0, 1'b0, 1'b1);
    send_stop(1'b1);

    // R6/R7 ownership and blanking window per setting
    for (int s = 0; s < 4; s++) begin
      int d;
      dly_sel_i = 2'(s);
      d = dly_of(2'(s));
      pulse_arm();
      send_start(1'b1);
      m_scl_low = 1'b1; s_scl_low = 1'b1;
      tick(1);
      chk("R6 tie host wins", {6'd0, sec_scl_oe_o, host_scl_oe_o}, 8'b10);
      s_scl_low = 1'b0;
      tick(3);
      s_sda_low = 1'b1;
      tick(3);
      chk("R6 owner ignores other side", {7'd0, host_sda_oe_o}, 8'd0);
      m_sda_low = 1'b0;
      tick(d + 1);
      chk("R7 blank window held", {7'd0, host_sda_oe_o}, 8'd0);
      tick(1);
      chk("R7 takeover after window", {7'd0, host_sda_oe_o}, 8'd1);
      s_sda_low = 1'b0;
      tick(HP);
      send_stop(1'b1);
    end

    for (int n = 0; n < 14; n++) begin
      dly_sel_i = 2'($urandom_range(3));
      if ($urandom_range(2) != 0) pulse_arm();
      run_msg(1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule